// File: doc/BRIEF.md
# Radio Operating-State Sequencer

This block decides which operating state the digital core of a packet radio is in. Software and other logic send it single-cycle command pulses: start transmit, start receive, go idle, flush the transmit FIFO, flush the receive FIFO, and a soft reset. It also watches four status inputs: calibration finished, synthesizer locked, transmit FIFO underflow and receive FIFO overflow. The state is kept in a register and shown on an 8-bit output as a fixed numeric code that software can read back. A 3-bit summary output, derived from that code, is meant for a status byte.

A transmit or receive request made from idle always passes through a synthesizer-lock phase before the radio path is active. When the 2-bit calibration-mode input selects automatic calibration, the request first passes through a calibration phase and a one-cycle bandwidth-boost phase. FIFO errors put the machine into sticky error states. Only the matching flush pulse, or a soft reset, leaves them. The calibration engine and the synthesizer are not part of the block; they are seen only through their done and lock inputs.

Top module: `rcs_ctrl`

## Requirements
- R1: After the synchronous active-low reset, `state_code` is 0x01 (idle) and `state_summary` is 3'b000.
- R2: `state_code` only ever takes one of these values: 0x01 idle, 0x08 calibrate, 0x09 bandwidth boost, 0x0A synthesizer lock, 0x0D receive, 0x11 receive overflow, 0x13 transmit, 0x16 transmit underflow.
- R3: When `autocal_mode` is 2'b01, a `cmd_tx` or `cmd_rx` pulse in idle moves the machine to 0x08 on the next cycle. It stays at 0x08 until `cal_done` is high. It then spends exactly one cycle at 0x09 and moves on to 0x0A.
- R4: When `autocal_mode` is any value other than 2'b01, a `cmd_tx` or `cmd_rx` pulse in idle moves the machine straight to 0x0A on the next cycle.
- R5: The machine stays at 0x0A until `synth_lock` is high. It then enters 0x13 if the request that left idle was a transmit request, or 0x0D if it was a receive request. When `cmd_tx` and `cmd_rx` arrive together in idle, transmit wins.
- R6: A `cmd_idle` pulse in 0x08, 0x09, 0x0A, 0x0D or 0x13 returns the machine to 0x01 on the next cycle. If a FIFO error arrives in the same cycle, `cmd_idle` wins.
- R7: `txf_underflow` in 0x13 moves the machine to 0x16, and `rxf_overflow` in 0x0D moves it to 0x11. Each error state holds until its own flush pulse arrives (`cmd_flush_tx` for 0x16, `cmd_flush_rx` for 0x11), which returns the machine to 0x01. `cmd_idle`, `cmd_tx`, `cmd_rx` and the other flush pulse leave an error state unchanged.
- R8: `cmd_flush_tx` has an effect only in idle or in 0x16. In any other state the state code does not change because of it.
- R9: A `cmd_reset` pulse moves the machine to 0x01 on the next cycle from any state, and it overrides every other input in that cycle.
- R10: `state_summary` is 000 in idle, 001 in receive, 010 in transmit, 011 in calibrate, boost or lock, 110 in receive overflow and 111 in transmit underflow.
- R11: `cmd_tx` and `cmd_rx` have no effect outside idle. `txf_underflow` has no effect outside 0x13, and `rxf_overflow` has no effect outside 0x0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_tx | input | 1 | One-cycle request to transmit |
| cmd_rx | input | 1 | One-cycle request to receive |
| cmd_idle | input | 1 | One-cycle request to go idle |
| cmd_flush_tx | input | 1 | One-cycle transmit FIFO flush |
| cmd_flush_rx | input | 1 | One-cycle receive FIFO flush |
| cmd_reset | input | 1 | One-cycle soft reset |
| autocal_mode | input | 2 | Calibration mode; 2'b01 means calibrate on leaving idle |
| cal_done | input | 1 | Calibration engine finished |
| synth_lock | input | 1 | Synthesizer locked |
| txf_underflow | input | 1 | Transmit FIFO underflow |
| rxf_overflow | input | 1 | Receive FIFO overflow |
| state_code | output | 8 | Current state as a numeric code |
| state_summary | output | 3 | 3-bit state class for a status byte |

## Verification
The bench targets the following corner cases, and each one shows up as a specific wrong state code:
- The boost phase lasting exactly one cycle. A design that skips it, or repeats it, shows the wrong code in the cycle after calibration.
- Transmit and receive requests arriving together. A design that remembers the wrong one locks into receive.
- The sticky error states. A design that lets `cmd_idle` or the wrong flush pulse out of an error state, or that accepts a transmit flush while receiving, returns to idle too early.
- An idle request and a FIFO error in the same cycle, and a soft reset combined with other pulses. Here the bench checks which input has priority.

A long pseudo-random pulse sequence then runs all transitions against the reference model.

// File: rtl/rcs_pkg.sv
// Package: shared state codes and widths for the radio operating-state sequencer.
// Assumes: the state codes are read back by software, so their values are fixed.
package rcs_pkg;
    localparam int CODE_W    = 8;
    localparam int SUM_W     = 3;
    localparam int AUTOCAL_W = 2;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE  = 8'h01,
        ST_CAL   = 8'h08,
        ST_BOOST = 8'h09,
        ST_LOCK  = 8'h0A,
        ST_RX    = 8'h0D,
        ST_RXOVF = 8'h11,
        ST_TX    = 8'h13,
        ST_TXUND = 8'h16
    } rcs_state_e;
endpackage

// File: rtl/rcs_next_state.sv
// Module: next-state logic of the sequencer (purely combinational).
// Assumes: every command input is a single-cycle pulse; cmd_reset has top priority.
module rcs_next_state
    import rcs_pkg::*;
#(
    parameter logic [AUTOCAL_W-1:0] AUTOCAL_ON = 2'b01
) (
    input  rcs_state_e           cur,
    input  logic                 s_tx,
    input  logic                 s_rx,
    input  logic                 s_idle,
    input  logic                 s_ftx,
    input  logic                 s_frx,
    input  logic                 s_rst,
    input  logic [AUTOCAL_W-1:0] autocal,
    input  logic                 cal_done,
    input  logic                 lock,
    input  logic                 und,
    input  logic                 ovf,
    input  logic                 dir_tx,
    output rcs_state_e           nxt,
    output logic                 capture
);
    // Choose the next state from the current state, the command pulses and the status inputs.
    always_comb begin
        nxt     = cur;
        capture = 1'b0;
        if (s_rst) begin
            nxt = ST_IDLE;
        end else begin
            unique case (cur)
                ST_IDLE: begin
                    if (s_tx || s_rx) begin
                        capture = 1'b1;
                        nxt     = (autocal == AUTOCAL_ON) ? ST_CAL : ST_LOCK;
                    end
                end
                ST_CAL:   nxt = s_idle ? ST_IDLE : (cal_done ? ST_BOOST : ST_CAL);
                ST_BOOST: nxt = s_idle ? ST_IDLE : ST_LOCK;
                ST_LOCK: begin
                    if (s_idle)    nxt = ST_IDLE;
                    else if (lock) nxt = dir_tx ? ST_TX : ST_RX;
                end
                ST_TX:    nxt = s_idle ? ST_IDLE : (und ? ST_TXUND : ST_TX);
                ST_RX:    nxt = s_idle ? ST_IDLE : (ovf ? ST_RXOVF : ST_RX);
                ST_TXUND: nxt = s_ftx ? ST_IDLE : ST_TXUND;
                ST_RXOVF: nxt = s_frx ? ST_IDLE : ST_RXOVF;
                default:  nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rcs_dir_latch.sv
// Module: remembers whether the request that left idle was transmit or receive.
// Assumes: capture is high only in the cycle the machine leaves idle; transmit wins a tie.
module rcs_dir_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic want_tx,
    output logic dir_tx
);
    // Store the requested direction when leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_tx <= 1'b0;
        else if (capture) dir_tx <= want_tx;
    end
endmodule

// File: rtl/rcs_summary.sv
// Module: turns the full state code into the 3-bit class used in a status byte.
// Assumes: only the eight legal codes reach it; anything else reads as idle.
module rcs_summary
    import rcs_pkg::*;
(
    input  rcs_state_e       st,
    output logic [SUM_W-1:0] summary
);
    // Map each state to its summary class.
    always_comb begin
        unique case (st)
            ST_RX:                     summary = 3'b001;
            ST_TX:                     summary = 3'b010;
            ST_CAL, ST_BOOST, ST_LOCK: summary = 3'b011;
            ST_RXOVF:                  summary = 3'b110;
            ST_TXUND:                  summary = 3'b111;
            default:                   summary = 3'b000;
        endcase
    end
endmodule

// File: rtl/rcs_ctrl.sv
// Module: top of the radio operating-state sequencer. It holds the state register
//         and wires the next-state logic, the direction latch and the summary encoder.
// Assumes: command inputs are one-cycle pulses; calibration and lock come from outside.
module rcs_ctrl
    import rcs_pkg::*;
#(
    parameter logic [AUTOCAL_W-1:0] AUTOCAL_ON = 2'b01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_tx,
    input  logic                 cmd_rx,
    input  logic                 cmd_idle,
    input  logic                 cmd_flush_tx,
    input  logic                 cmd_flush_rx,
    input  logic                 cmd_reset,
    input  logic [AUTOCAL_W-1:0] autocal_mode,
    input  logic                 cal_done,
    input  logic                 synth_lock,
    input  logic                 txf_underflow,
    input  logic                 rxf_overflow,
    output logic [CODE_W-1:0]    state_code,
    output logic [SUM_W-1:0]     state_summary
);
    rcs_state_e st_q, st_d;
    logic       capture, dir_tx;

    rcs_next_state #(.AUTOCAL_ON(AUTOCAL_ON)) u_next (
        .cur(st_q), .s_tx(cmd_tx), .s_rx(cmd_rx), .s_idle(cmd_idle),
        .s_ftx(cmd_flush_tx), .s_frx(cmd_flush_rx), .s_rst(cmd_reset),
        .autocal(autocal_mode), .cal_done(cal_done), .lock(synth_lock),
        .und(txf_underflow), .ovf(rxf_overflow), .dir_tx(dir_tx),
        .nxt(st_d), .capture(capture)
    );

    rcs_dir_latch u_dir (
        .clk(clk), .rst_n(rst_n), .capture(capture), .want_tx(cmd_tx), .dir_tx(dir_tx)
    );

    rcs_summary u_sum (.st(st_q), .summary(state_summary));

    // State register, idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign state_code = st_q;
endmodule

// File: rtl/rcs_ctrl_chk.sv
// Module: checker with temporal properties of the sequencer, bound to rcs_ctrl.
// Assumes: it sees only the ports of the top module.
module rcs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_tx,
    input logic       cmd_rx,
    input logic       cmd_idle,
    input logic       cmd_flush_tx,
    input logic       cmd_flush_rx,
    input logic       cmd_reset,
    input logic [1:0] autocal_mode,
    input logic       cal_done,
    input logic       synth_lock,
    input logic       txf_underflow,
    input logic       rxf_overflow,
    input logic [7:0] state_code,
    input logic [2:0] state_summary
);
    logic active;
    assign active = (state_code == 8'h08) || (state_code == 8'h09) || (state_code == 8'h0A) ||
                    (state_code == 8'h0D) || (state_code == 8'h13);

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_code inside {8'h01, 8'h08, 8'h09, 8'h0A, 8'h0D, 8'h11, 8'h13, 8'h16});

    a_r3_boost_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h09 && !cmd_reset && !cmd_idle) |=> state_code == 8'h0A);

    a_r3_cal_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h01 && !cmd_reset && (cmd_tx || cmd_rx) && autocal_mode == 2'b01)
        |=> state_code == 8'h08);

    a_r4_no_cal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h01 && !cmd_reset && (cmd_tx || cmd_rx) && autocal_mode != 2'b01)
        |=> state_code == 8'h0A);

    a_r6_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_idle) |=> state_code == 8'h01);

    a_r7_txund_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h16 && !cmd_flush_tx && !cmd_reset) |=> state_code == 8'h16);

    a_r7_rxovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h11 && !cmd_flush_rx && !cmd_reset) |=> state_code == 8'h11);

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> state_code == 8'h01);

    a_r10_summary_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 8'h16) |-> state_summary == 3'b111);
endmodule

bind rcs_ctrl rcs_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx), .cmd_idle(cmd_idle),
    .cmd_flush_tx(cmd_flush_tx), .cmd_flush_rx(cmd_flush_rx), .cmd_reset(cmd_reset),
    .autocal_mode(autocal_mode), .cal_done(cal_done), .synth_lock(synth_lock),
    .txf_underflow(txf_underflow), .rxf_overflow(rxf_overflow),
    .state_code(state_code), .state_summary(state_summary)
);

// File: tb/rcs_ctrl_tb_top.sv
// Bench: a behavioural reference model is compared with the design on every clock.
module rcs_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_tx = 0, cmd_rx = 0, cmd_idle = 0, cmd_flush_tx = 0, cmd_flush_rx = 0, cmd_reset = 0;
    logic [1:0] autocal_mode = 2'b01;
    logic       cal_done = 0, synth_lock = 0, txf_underflow = 0, rxf_overflow = 0;
    logic [7:0] state_code;
    logic [2:0] state_summary;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int    m_st = 8'h01;
    bit    m_tx = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    rcs_ctrl dut_i (.*);

    localparam int B_TX = 1, B_RX = 2, B_IDL = 4, B_FTX = 8, B_FRX = 16,
                   B_RST = 32, B_CD = 64, B_LK = 128, B_UND = 256, B_OVF = 512;

    // Reference model: updates on each rising edge from the inputs the bench drove.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 8'h01;
            m_tx = 0;
        end else if (cmd_reset) begin
            m_st = 8'h01;
        end else if (m_st == 8'h01) begin
            if (cmd_tx || cmd_rx) begin
                m_tx = cmd_tx;
                m_st = (autocal_mode == 2'b01) ? 8'h08 : 8'h0A;
            end
        end else if (m_st == 8'h11) begin
            if (cmd_flush_rx) m_st = 8'h01;
        end else if (m_st == 8'h16) begin
            if (cmd_flush_tx) m_st = 8'h01;
        end else if (cmd_idle) begin
            m_st = 8'h01;
        end else if (m_st == 8'h08) begin
            if (cal_done) m_st = 8'h09;
        end else if (m_st == 8'h09) begin
            m_st = 8'h0A;
        end else if (m_st == 8'h0A) begin
            if (synth_lock) m_st = m_tx ? 8'h13 : 8'h0D;
        end else if (m_st == 8'h13) begin
            if (txf_underflow) m_st = 8'h16;
        end else if (m_st == 8'h0D) begin
            if (rxf_overflow) m_st = 8'h11;
        end
    end

    function automatic logic [2:0] exp_sum(int s);
        case (s)
            8'h0D: return 3'b001;
            8'h13: return 3'b010;
            8'h08, 8'h09, 8'h0A: return 3'b011;
            8'h11: return 3'b110;
            8'h16: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic compare();
        n_cmp++;
        if (state_code !== m_st[7:0]) begin
            n_bad++;
            $display("FAIL %s state_code actual=%02h expected=%02h", cur_req, state_code, m_st[7:0]);
        end
        n_cmp++;
        if (state_summary !== exp_sum(m_st)) begin
            n_bad++;
            $display("FAIL R10 (%s) state_summary actual=%b expected=%b", cur_req,
                     state_summary, exp_sum(m_st));
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next pulses.
    task automatic cyc(int m);
        @(negedge clk);
        compare();
        cmd_tx = m[0]; cmd_rx = m[1]; cmd_idle = m[2]; cmd_flush_tx = m[3];
        cmd_flush_rx = m[4]; cmd_reset = m[5]; cal_done = m[6]; synth_lock = m[7];
        txf_underflow = m[8]; rxf_overflow = m[9];
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int lf = 32'h1ACE5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; cyc(0);
        // R3: calibration path to receive
        cur_req = "R3"; autocal_mode = 2'b01; cyc(B_RX); cyc(0); cyc(0); cyc(B_CD); cyc(0); cyc(0);
        cur_req = "R5"; cyc(0); cyc(B_LK); cyc(0);
        cur_req = "R11"; cyc(B_TX); cyc(B_UND); cyc(0);
        cur_req = "R8"; cyc(B_FTX); cyc(0);
        cur_req = "R7"; cyc(B_OVF); cyc(B_IDL); cyc(B_FTX); cyc(B_TX); cyc(0); cyc(B_FRX); cyc(0);
        // R4: direct to lock, both requests -> transmit
        cur_req = "R4"; autocal_mode = 2'b00; cyc(B_TX | B_RX); cyc(0);
        cur_req = "R5"; cyc(B_LK); cyc(0);
        cur_req = "R8"; cyc(B_FTX); cyc(0);
        cur_req = "R7"; cyc(B_UND); cyc(B_IDL); cyc(B_FRX); cyc(0); cyc(B_FTX); cyc(0);
        autocal_mode = 2'b11; cur_req = "R4"; cyc(B_RX); cyc(0);
        // R6: idle from lock, from calibration, and over an underflow
        cur_req = "R6"; cyc(B_IDL); cyc(0);
        autocal_mode = 2'b01; cyc(B_TX); cyc(B_IDL); cyc(0);
        autocal_mode = 2'b10; cyc(B_TX); cyc(B_LK); cyc(B_IDL | B_UND); cyc(0);
        // R9: soft reset from error and from calibration, with other pulses
        cur_req = "R9"; cyc(B_TX); cyc(B_LK); cyc(B_UND); cyc(B_RST); cyc(0);
        autocal_mode = 2'b01; cyc(B_RX); cyc(B_RST | B_CD | B_IDL); cyc(0);
        cyc(B_RST | B_TX); cyc(0);
        // R2: pseudo-random pulse sequence
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int m = 0;
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 0);
            for (int b = 0; b < 10; b++)
                if (((lf >> (b * 3)) & 7) == 0 || (b >= 6 && ((lf >> b) & 3) == 0)) m |= (1 << b);
            if ((lf & 32'h1F0000) == 0) m |= B_RST;
            else m &= ~B_RST;
            autocal_mode = lf[21:20];
            cyc(m);
        end
        cyc(0);
        done = 1;
        finish_run();
    end
endmodule